// File: doc/BRIEF.md
# Slow-Clock Time Counter with Coherent Snapshot

This block keeps a 64-bit count of slow-clock cycles and lets a fast bus domain read it safely. The counter runs on its own in the slow domain. It is never read directly. A bus-side update pulse asks the slow domain to copy the count into a holding register. When that copy has reached the bus domain, a valid flag rises. The result is then presented as a low 32-bit word and a high 32-bit word.

Both words come from one capture, so software never sees a high word and a low word taken at different moments. Software starts a capture with `upd_req`, waits for `snap_vld`, reads the two words, and may then lower the flag with `vld_clr`.

Requests travel into the slow domain as a toggle, which is synchronised there and turned back into a pulse. The completion travels back to the bus domain the same way. While a capture is in flight, any further update request is dropped.

Top module: `snap_time_counter`

## Requirements
- R1: While reset is applied and after it, until the first capture completes, `snap_vld` is 0 and `snap_lo` and `snap_hi` are 0.
- R2: The counter resets to 0 and increments on every slow-clock rising edge while `slow_rst_n` is high. The 64-bit snapshot `{snap_hi, snap_lo}` equals the counter value at some slow edge between the accepted request and the rise of `snap_vld`, so successive snapshots strictly increase.
- R3: An update (`upd_req` high at a bus-clock edge while no capture is in flight) makes `snap_vld` 0 from that edge until the new capture completes.
- R4: `snap_vld` rises no later than 4 slow-clock periods plus 6 bus-clock cycles after the edge that accepted the update. Each accepted update produces exactly one rise.
- R5: `vld_clr` high at a bus-clock edge makes `snap_vld` 0 after that edge and leaves `snap_lo`/`snap_hi` unchanged. If a capture completes in that same cycle, the completion wins.
- R6: `snap_lo`/`snap_hi` change only in the cycle in which `snap_vld` rises, and they are held otherwise.
- R7: `upd_req` asserted while a capture is in flight is ignored. It starts no second capture, and the snapshot and flag stay as the first request left them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-domain clock |
| bus_rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| slow_clk | input | 1 | Slow timekeeping clock |
| slow_rst_n | input | 1 | Slow-domain asynchronous reset, active low |
| upd_req | input | 1 | One-cycle request to capture the counter |
| vld_clr | input | 1 | One-cycle request to lower the valid flag |
| snap_vld | output | 1 | Snapshot is complete and coherent |
| snap_lo | output | 32 | Bits 31:0 of the snapshot |
| snap_hi | output | 32 | Bits 63:32 of the snapshot |

## Verification
The loss of `snap_vld` after an accepted update is due one bus cycle later. The bench samples it at the falling edge that follows the accepting edge. The same one-cycle rule applies to `vld_clr`.

The rise of the flag falls inside a window set by the synchroniser depth and the ratio of the two clocks. The scoreboard records the bus-cycle number of each accepted request and bounds the distance to the rise at 36 edges for the clock pair used. It also checks the captured value against slow-edge counts taken at request time and at rise time.

Hold checks sample the words 20 to 40 cycles after the rise, and check that an ignored request brings no second rise.

// File: rtl/snap_time_pkg.sv
package snap_time_pkg;
    localparam int unsigned CNT_W  = 64;
    localparam int unsigned WORD_W = 32;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic busy;
        logic vld;
        logic req_tgl;
        cnt_t data;
    } bus_st_t;

    typedef struct packed {
        cnt_t ctr;
        cnt_t hold;
        logic done_tgl;
    } slow_st_t;
endpackage

// File: rtl/snap_sync.sv
module snap_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_i,
    output logic pulse_o
);
    logic [STAGES-1:0] stg_d, stg_q;
    logic              last_d, last_q;

    always_comb begin
        stg_d  = {stg_q[STAGES-2:0], tgl_i};
        last_d = stg_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q  <= '0;
            last_q <= 1'b0;
        end else begin
            stg_q  <= stg_d;
            last_q <= last_d;
        end
    end

    assign pulse_o = stg_q[STAGES-1] ^ last_q;

    AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o); // R4
endmodule

// File: rtl/snap_slow_core.sv
module snap_slow_core
    import snap_time_pkg::*;
(
    input  logic slow_clk,
    input  logic slow_rst_n,
    input  logic req_pulse_i,
    output cnt_t hold_o,
    output logic done_tgl_o
);
    slow_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ctr = st_q.ctr + cnt_t'(1);
        if (req_pulse_i) begin
            st_d.hold     = st_q.ctr;
            st_d.done_tgl = ~st_q.done_tgl;
        end
    end

    always_ff @(posedge slow_clk or negedge slow_rst_n) begin
        if (!slow_rst_n) st_q <= '0;
        else             st_q <= st_d;
    end

    assign hold_o     = st_q.hold;
    assign done_tgl_o = st_q.done_tgl;

    AST_CTR_STEP: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        (st_q.ctr != '0) |=> (st_q.ctr == $past(st_q.ctr) + cnt_t'(1))); // R2
    AST_HOLD_ON_REQ: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        $changed(st_q.hold) |-> $past(req_pulse_i)); // R6
endmodule

// File: rtl/snap_bus_ctl.sv
module snap_bus_ctl
    import snap_time_pkg::*;
(
    input  logic bus_clk,
    input  logic bus_rst_n,
    input  logic upd_req_i,
    input  logic vld_clr_i,
    input  logic done_pulse_i,
    input  cnt_t hold_i,
    output logic req_tgl_o,
    output logic vld_o,
    output cnt_t data_o
);
    bus_st_t st_d, st_q;
    logic    accept;

    always_comb begin
        st_d   = st_q;
        accept = upd_req_i && !st_q.busy;
        if (vld_clr_i) st_d.vld = 1'b0;
        if (done_pulse_i && st_q.busy) begin
            st_d.busy = 1'b0;
            st_d.vld  = 1'b1;
            st_d.data = hold_i;
        end
        if (accept) begin
            st_d.busy    = 1'b1;
            st_d.vld     = 1'b0;
            st_d.req_tgl = ~st_q.req_tgl;
        end
    end

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign req_tgl_o = st_q.req_tgl;
    assign vld_o     = st_q.vld;
    assign data_o    = st_q.data;

    AST_UPD_DROPS_VLD: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (upd_req_i && !st_q.busy) |=> !vld_o); // R3
    AST_NO_VLD_IN_FLIGHT: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        st_q.busy |-> !vld_o); // R3
    AST_CLR_DROPS_VLD: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (vld_clr_i && !done_pulse_i) |=> !vld_o); // R5
    AST_DATA_ON_RISE: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $changed(data_o) |-> $rose(vld_o)); // R6
    AST_BUSY_IGNORES_UPD: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (upd_req_i && st_q.busy && !done_pulse_i) |=> $stable(req_tgl_o)); // R7
endmodule

// File: rtl/snap_time_counter.sv
module snap_time_counter
    import snap_time_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              slow_clk,
    input  logic              slow_rst_n,
    input  logic              upd_req,
    input  logic              vld_clr,
    output logic              snap_vld,
    output logic [WORD_W-1:0] snap_lo,
    output logic [WORD_W-1:0] snap_hi
);
    logic req_tgl, req_pulse, done_tgl, done_pulse;
    cnt_t hold, data;

    snap_bus_ctl u_bus (
        .bus_clk      (bus_clk),
        .bus_rst_n    (bus_rst_n),
        .upd_req_i    (upd_req),
        .vld_clr_i    (vld_clr),
        .done_pulse_i (done_pulse),
        .hold_i       (hold),
        .req_tgl_o    (req_tgl),
        .vld_o        (snap_vld),
        .data_o       (data)
    );

    snap_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk     (slow_clk),
        .rst_n   (slow_rst_n),
        .tgl_i   (req_tgl),
        .pulse_o (req_pulse)
    );

    snap_slow_core u_slow (
        .slow_clk    (slow_clk),
        .slow_rst_n  (slow_rst_n),
        .req_pulse_i (req_pulse),
        .hold_o      (hold),
        .done_tgl_o  (done_tgl)
    );

    snap_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk     (bus_clk),
        .rst_n   (bus_rst_n),
        .tgl_i   (done_tgl),
        .pulse_o (done_pulse)
    );

    assign snap_lo = data[WORD_W-1:0];
    assign snap_hi = data[CNT_W-1:WORD_W];
endmodule

// File: tb/snap_time_counter_tb.sv
`timescale 1ns/100ps
module snap_time_counter_tb;
    localparam int LAT_MAX = 36;

    logic        bus_clk = 1'b0, slow_clk = 1'b0;
    logic        bus_rst_n = 1'b0, slow_rst_n = 1'b0;
    logic        upd_req = 1'b0, vld_clr = 1'b0;
    logic        snap_vld;
    logic [31:0] snap_lo, snap_hi;

    int errors = 0, checks = 0;
    int unsigned cyc = 0;
    longint unsigned slow_cnt = 0;

    typedef struct {
        longint unsigned lo_bound;
        int unsigned     acc_cyc;
    } exp_t;
    exp_t sb_q[$];
    logic [63:0] last_snap = '0;

    snap_time_counter u_dut (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
        .upd_req(upd_req), .vld_clr(vld_clr), .snap_vld(snap_vld), .snap_lo(snap_lo), .snap_hi(snap_hi)
    );

    always #5 bus_clk = ~bus_clk;
    initial begin
        #2.5;
        forever #37 slow_clk = ~slow_clk;
    end
    always @(posedge bus_clk) cyc++;
    always @(posedge slow_clk) if (slow_rst_n) slow_cnt++;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] snap();
        return {snap_hi, snap_lo};
    endfunction

    task automatic do_update(input bit expect_accept);
        exp_t e;
        @(negedge bus_clk);
        upd_req    = 1'b1;
        e.lo_bound = slow_cnt;
        e.acc_cyc  = cyc + 1;
        if (expect_accept) sb_q.push_back(e);
        @(negedge bus_clk);
        upd_req = 1'b0;
        if (expect_accept) chk(snap_vld == 1'b0, "R3", "vld after update", 64'(snap_vld), 64'd0);
    endtask

    task automatic wait_vld();
        int n = 0;
        while (!snap_vld && n < 2 * LAT_MAX) begin
            @(negedge bus_clk);
            n++;
        end
    endtask

    // monitor: pops expectations on every rise of the valid flag
    initial begin
        logic prev = 1'b0;
        exp_t e;
        wait (bus_rst_n);
        forever begin
            @(negedge bus_clk);
            if (snap_vld && !prev) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected valid rise", 64'd1, 64'd0);
                end else begin
                    e = sb_q.pop_front();
                    chk(snap() >= e.lo_bound && snap() <= slow_cnt, "R2", "value in window",
                        snap(), 64'(e.lo_bound));
                    chk(snap() > last_snap, "R2", "increasing", snap(), last_snap);
                    chk(cyc - e.acc_cyc <= LAT_MAX, "R4", "latency",
                        64'(cyc - e.acc_cyc), 64'(LAT_MAX));
                    last_snap = snap();
                end
            end
            prev = snap_vld;
        end
    end

    initial begin
        #(20000 * 10);
        chk(1'b0, "R4", "watchdog expired", 64'd0, 64'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] d0;
        int gaps[4] = '{3, 17, 50, 120};
        repeat (4) @(negedge bus_clk);
        chk(snap_vld == 1'b0, "R1", "vld in reset", 64'(snap_vld), 64'd0);
        @(negedge slow_clk);
        slow_rst_n = 1'b1;
        @(negedge bus_clk);
        bus_rst_n = 1'b1;
        repeat (3) @(negedge bus_clk);
        chk(snap_vld == 1'b0, "R1", "vld after reset", 64'(snap_vld), 64'd0);
        chk(snap_lo == 32'd0, "R1", "lo after reset", 64'(snap_lo), 64'd0);
        chk(snap_hi == 32'd0, "R1", "hi after reset", 64'(snap_hi), 64'd0);

        foreach (gaps[i]) begin
            repeat (gaps[i]) @(negedge bus_clk);
            do_update(1'b1);
            wait_vld();
            chk(snap_vld == 1'b1, "R4", "vld seen", 64'(snap_vld), 64'd1);
            d0 = snap();
            repeat (20) @(negedge bus_clk);
            chk(snap() == d0, "R6", "words held", snap(), d0);
        end

        // clear lowers the flag, words unchanged
        @(negedge bus_clk);
        vld_clr = 1'b1;
        @(negedge bus_clk);
        vld_clr = 1'b0;
        chk(snap_vld == 1'b0, "R5", "vld after clear", 64'(snap_vld), 64'd0);
        chk(snap() == d0, "R5", "words after clear", snap(), d0);
        repeat (5) @(negedge bus_clk);
        chk(snap_vld == 1'b0, "R5", "vld stays clear", 64'(snap_vld), 64'd0);

        // second request while in flight is dropped
        do_update(1'b1);
        @(negedge bus_clk);
        do_update(1'b0);
        wait_vld();
        d0 = snap();
        repeat (40) @(negedge bus_clk);
        chk(snap_vld == 1'b1, "R7", "vld kept", 64'(snap_vld), 64'd1);
        chk(snap() == d0, "R7", "words kept", snap(), d0);

        repeat (5) @(negedge bus_clk);
        chk(sb_q.size() == 0, "R4", "all captures done", 64'(sb_q.size()), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule